// File: doc/BRIEF.md
# Completion Interrupt Coalescer

The block keeps one queue's count of finished instructions that asked to be reported. It decides when the completion interrupt line goes high. Every completion pulse carries a flag that says whether that instruction wants an interrupt. Only flagged completions add to the count. The interrupt is held back until enough results have piled up or until results have waited long enough. The waiting limit is a 16-bit setting scaled by 1024 clock cycles.

Software talks to the block through one write port with a 2-bit register select. It acknowledges serviced completions by writing how many to take off the count, and that write also restarts the wait timer. Software can also load the count directly, program both limits and switch the interrupt output on and off. The current count is always visible on a readback output. The interrupt decision is remade every cycle from the stored state. So if an acknowledge leaves the count still at or above the count limit, the line comes straight back up. This closes the race between an acknowledge and a completion that arrives at the same moment.

Top module: `irq_coalescer`

## Requirements
- R1: After reset the count reads 0, the interrupt is low, both limits are 0 and the interrupt enable is off, so a flagged completion right after reset gives a count of 1 and a low interrupt.
- R2: A completion pulse (`cmpl_valid`=1) raises the count by one at the next clock edge only when `cmpl_doneint`=1; with `cmpl_doneint`=0 the count is unchanged.
- R3: While the count is 0 the interrupt is low and the wait timer is held at 0.
- R4: With the enable on and the count nonzero, the interrupt is high whenever count >= count limit; a count limit of 0 acts as a limit of 1.
- R5: With the enable on, the interrupt goes high once the count has been nonzero for time limit x 1024 cycles since the count last became nonzero or was restarted. Equivalently, it goes high at the 1024xT-th clock edge after that edge; a time limit of 0 turns time-based release off.
- R6: A write with `reg_addr`=0 (acknowledge) subtracts `reg_wdata[19:0]` from the count and clears the wait timer; a value larger than the count leaves 0.
- R7: The interrupt is evaluated again in the cycle right after an acknowledge, so a count that is still at or above the count limit keeps the interrupt high with no gap.
- R8: A write with `reg_addr`=1 loads `reg_wdata[19:0]` into the count and clears the wait timer.
- R9: A write with `reg_addr`=3 sets the enable from `reg_wdata[0]`; with the enable off the interrupt is low while counting and timing go on, so turning the enable on shows any condition that has already been met at once.
- R10: A flagged completion and an acknowledge in the same cycle leave old count + 1 - acknowledge value (clamped at 0).
- R11: A write with `reg_addr`=2 loads the count limit from `reg_wdata[19:0]` and the time limit from `reg_wdata[35:20]`; `done_cnt` shows the count register from the edge after each change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpl_valid | input | 1 | One-cycle pulse: an instruction finished |
| cmpl_doneint | input | 1 | That instruction asked for a completion interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 acknowledge, 1 count load, 2 limits, 3 enable |
| reg_wdata | input | 36 | Write data |
| irq | output | 1 | Completion interrupt |
| done_cnt | output | 20 | Current completion count |

## Verification
The count path is driven with unflagged and flagged completions and with acknowledges of exact, partial and oversized values. Each result separates the correct add, ignore, subtract and clamp behaviour from an off-by-one or a wrap. A completion is also sent in the same cycle as an acknowledge, which tells apart a design that drops one of the two updates. The time path is probed one cycle before and exactly at the 1024-cycle point, and the checks are repeated with the time limit at 0 and with the enable off. These cases separate a wrong scale, a timer that is not held or restarted, and a mask that wrongly stops the timer.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
    localparam int CNT_W      = 20;
    localparam int TW_W       = 16;
    localparam int NW_W       = 20;
    localparam int SCALE_LOG2 = 10;
    localparam int TMR_W      = TW_W + SCALE_LOG2;
    localparam int DATA_W     = TW_W + NW_W;

    typedef enum logic [1:0] {
        SEL_ACK    = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_LIMITS = 2'd2,
        SEL_ENABLE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [TW_W-1:0] time_lim;
        logic [NW_W-1:0] num_lim;
    } limits_t;

    function automatic logic [NW_W-1:0] eff_num(input logic [NW_W-1:0] n);
        return (n == '0) ? NW_W'(1) : n;
    endfunction
endpackage

// File: rtl/coal_counter.sv
module coal_counter #(
    parameter int W = irq_coal_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         ack_en,
    input  logic         load_en,
    input  logic [W-1:0] wvalue,
    output logic [W-1:0] count
);
    localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

    logic [W:0]   sum;
    logic [W-1:0] nxt;

    always_comb begin
        sum = {1'b0, count} + {{W{1'b0}}, inc};
        if (load_en) begin
            nxt = wvalue;
        end else if (ack_en) begin
            if ({1'b0, wvalue} > sum) nxt = '0;
            else if ((sum - {1'b0, wvalue}) > MAXV) nxt = '1;
            else nxt = W'(sum - {1'b0, wvalue});
        end else begin
            nxt = (sum > MAXV) ? '1 : W'(sum);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= nxt;
    end

    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !ack_en && !load_en && count != '1) |=> count == $past(count) + W'(1));
    // R6
    ack_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_en && !inc && !load_en && wvalue <= count) |=> count == $past(count) - $past(wvalue));
    // R8
    load_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> count == $past(wvalue));
endmodule

// File: rtl/coal_timer.sv
module coal_timer #(
    parameter int W = irq_coal_pkg::TMR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         restart,
    output logic [W-1:0] tmr
);
    always_ff @(posedge clk) begin
        if (rst || restart || !active) tmr <= '0;
        else if (tmr != '1)            tmr <= tmr + W'(1);
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !active |=> tmr == '0);
    // R6
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> tmr == '0);
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !restart && tmr == '1) |=> tmr == '1);
endmodule

// File: rtl/coal_decide.sv
module coal_decide
    import irq_coal_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int TW = TMR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] count,
    input  logic [TW-1:0] tmr,
    input  limits_t       limits,
    input  logic          enable,
    output logic          irq
);
    logic [TW-1:0] tmr_thr;
    logic          by_num;
    logic          by_time;

    always_comb begin
        tmr_thr = {limits.time_lim, {SCALE_LOG2{1'b0}}};
        by_num  = count >= CW'(eff_num(limits.num_lim));
        by_time = (limits.time_lim != '0) && (tmr >= tmr_thr);
        irq     = enable && (count != '0) && (by_num || by_time);
    end

    // R3
    zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !irq);
    // R9
    masked_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !irq);
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
    import irq_coal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmpl_valid,
    input  logic              cmpl_doneint,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              irq,
    output logic [CNT_W-1:0]  done_cnt
);
    reg_sel_e       sel;
    logic           ack_en, load_en, lim_en, ena_en;
    limits_t        limits_q;
    logic           enable_q;
    logic [TMR_W-1:0] tmr;

    always_comb begin
        sel     = reg_sel_e'(reg_addr);
        ack_en  = reg_wr && (sel == SEL_ACK);
        load_en = reg_wr && (sel == SEL_COUNT);
        lim_en  = reg_wr && (sel == SEL_LIMITS);
        ena_en  = reg_wr && (sel == SEL_ENABLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limits_q <= '0;
            enable_q <= 1'b0;
        end else begin
            if (lim_en) limits_q <= limits_t'(reg_wdata);
            if (ena_en) enable_q <= reg_wdata[0];
        end
    end

    coal_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst),
        .inc(cmpl_valid && cmpl_doneint),
        .ack_en(ack_en), .load_en(load_en),
        .wvalue(reg_wdata[CNT_W-1:0]),
        .count(done_cnt)
    );

    coal_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst),
        .active(done_cnt != '0),
        .restart(ack_en || load_en),
        .tmr(tmr)
    );

    coal_decide #(.CW(CNT_W), .TW(TMR_W)) u_dec (
        .clk(clk), .rst(rst),
        .count(done_cnt), .tmr(tmr),
        .limits(limits_q), .enable(enable_q),
        .irq(irq)
    );

    // R10
    same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmpl_valid && cmpl_doneint && ack_en && !load_en &&
         reg_wdata[CNT_W-1:0] <= done_cnt)
        |=> done_cnt == $past(done_cnt) + CNT_W'(1) - $past(reg_wdata[CNT_W-1:0]));
endmodule

// File: tb/irq_coalescer_tb.sv
`timescale 1ns/1ps
module irq_coalescer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmpl_valid = 1'b0, cmpl_doneint = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [35:0] reg_wdata = '0;
    logic        irq;
    logic [19:0] done_cnt;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    irq_coalescer dut_i (
        .clk(clk), .rst(rst), .cmpl_valid(cmpl_valid), .cmpl_doneint(cmpl_doneint),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .irq(irq), .done_cnt(done_cnt)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  addr;
        logic [35:0] data;
        logic        cv;
        logic        cd;
        logic [19:0] ecnt;
        logic        eirq;
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t VECS [19] = '{
        '{1'b1, 2'd2, 36'd3, 1'b0, 1'b0, 20'd0, 1'b0, 4'd11}, // R11 limits: num 3, time 0
        '{1'b1, 2'd3, 36'd1, 1'b0, 1'b0, 20'd0, 1'b0, 4'd9},  // R9 enable on
        '{1'b0, 2'd0, 36'd0, 1'b1, 1'b0, 20'd0, 1'b0, 4'd2},  // R2 unflagged ignored
        '{1'b0, 2'd0, 36'd0, 1'b1, 1'b1, 20'd1, 1'b0, 4'd2},  // R2
        '{1'b0, 2'd0, 36'd0, 1'b1, 1'b1, 20'd2, 1'b0, 4'd2},  // R2
        '{1'b0, 2'd0, 36'd0, 1'b1, 1'b1, 20'd3, 1'b1, 4'd4},  // R4 reaches limit
        '{1'b1, 2'd0, 36'd1, 1'b0, 1'b0, 20'd2, 1'b0, 4'd6},  // R6 ack 1
        '{1'b0, 2'd0, 36'd0, 1'b1, 1'b1, 20'd3, 1'b1, 4'd4},  // R4
        '{1'b1, 2'd0, 36'd2, 1'b1, 1'b1, 20'd2, 1'b0, 4'd10}, // R10 3+1-2
        '{1'b0, 2'd0, 36'd0, 1'b1, 1'b1, 20'd3, 1'b1, 4'd4},  // R4
        '{1'b1, 2'd0, 36'd5, 1'b0, 1'b0, 20'd0, 1'b0, 4'd6},  // R6 clamp
        '{1'b1, 2'd1, 36'd5, 1'b0, 1'b0, 20'd5, 1'b1, 4'd8},  // R8 load
        '{1'b1, 2'd0, 36'd1, 1'b0, 1'b0, 20'd4, 1'b1, 4'd7},  // R7 refire
        '{1'b1, 2'd3, 36'd0, 1'b0, 1'b0, 20'd4, 1'b0, 4'd9},  // R9 masked
        '{1'b0, 2'd0, 36'd0, 1'b1, 1'b1, 20'd5, 1'b0, 4'd9},  // R9 still counts
        '{1'b1, 2'd2, 36'd0, 1'b0, 1'b0, 20'd5, 1'b0, 4'd11}, // R11 num 0
        '{1'b1, 2'd3, 36'd1, 1'b0, 1'b0, 20'd5, 1'b1, 4'd9},  // R9 unmask
        '{1'b1, 2'd1, 36'd0, 1'b0, 1'b0, 20'd0, 1'b0, 4'd3},  // R3 zero count
        '{1'b0, 2'd0, 36'd0, 1'b1, 1'b1, 20'd1, 1'b1, 4'd4}   // R4 limit 0 acts as 1
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [1:0] addr, input logic [35:0] data,
                        input logic cv, input logic cd);
        reg_wr = wr; reg_addr = addr; reg_wdata = data;
        cmpl_valid = cv; cmpl_doneint = cd;
        @(negedge clk);
        reg_wr = 1'b0; cmpl_valid = 1'b0; cmpl_doneint = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 count", 32'(done_cnt), 0);
        check("R1 irq", 32'(irq), 0);
        step(1'b0, 2'd0, 36'd0, 1'b1, 1'b1);
        check("R1 count after cmpl", 32'(done_cnt), 1);
        check("R1 irq disabled", 32'(irq), 0);
        step(1'b1, 2'd1, 36'd0, 1'b0, 1'b0);

        for (int i = 0; i < 19; i++) begin
            step(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].cv, VECS[i].cd);
            check($sformatf("R%0d count vec %0d", VECS[i].rq, i), 32'(done_cnt), 32'(VECS[i].ecnt));
            check($sformatf("R%0d irq vec %0d", VECS[i].rq, i), 32'(irq), 32'(VECS[i].eirq));
        end

        // R5 time release: num limit 1000, time limit 1
        step(1'b1, 2'd2, (36'd1 << 20) | 36'd1000, 1'b0, 1'b0);
        step(1'b1, 2'd1, 36'd0, 1'b0, 1'b0);
        step(1'b0, 2'd0, 36'd0, 1'b1, 1'b1);
        repeat (1023) @(negedge clk);
        check("R5 before 1024", 32'(irq), 0);
        @(negedge clk);
        check("R5 at 1024", 32'(irq), 1);
        step(1'b1, 2'd0, 36'd0, 1'b0, 1'b0);
        check("R6 restart irq", 32'(irq), 0);
        check("R6 restart count", 32'(done_cnt), 1);

        // R5 time limit 0 disables time release
        step(1'b1, 2'd2, 36'd1000, 1'b0, 1'b0);
        repeat (2000) @(negedge clk);
        check("R5 time off", 32'(irq), 0);

        // R9 timing continues while masked
        step(1'b1, 2'd2, (36'd1 << 20) | 36'd1000, 1'b0, 1'b0);
        step(1'b1, 2'd3, 36'd0, 1'b0, 1'b0);
        step(1'b1, 2'd1, 36'd1, 1'b0, 1'b0);
        repeat (1100) @(negedge clk);
        check("R9 masked after time", 32'(irq), 0);
        step(1'b1, 2'd3, 36'd1, 1'b0, 1'b0);
        check("R9 unmask shows time", 32'(irq), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule